// File: doc/BRIEF.md
# Memory access protection checker

This block screens every data-memory request against two kinds of protection before the access reaches the cache. It holds a byte-granular limit for each of six segment registers and a small fully associative translation buffer. Each buffer entry maps a virtual page number to a physical page and carries a read-only flag and a cache-disable flag. For each request it returns the physical page, a miss indication and a cache-bypass indication one cycle later. Any protection fault is latched into one of two sticky flags: a general-protection flag for most faults, and a separate stack-fault flag for a stack segment overrun.

A request names a segment by a 3-bit code: ES=0, CS=1, SS=2, DS=3, FS=4, GS=5. It also carries the effective address within that segment, an access size, a write strobe, the virtual page number and an I/O-space marker. The size code gives the access width: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes. Segment limits and buffer entries are written through two narrow configuration ports. A configuration write takes effect for requests presented from the following cycle onward. The fault handler clears the sticky flags with a one-cycle clear pulse once it has taken the fault.

Top module: `mem_prot_check`

## Requirements
- R1: While reset is low and in the first cycle after it, rsp_valid, rsp_miss, rsp_bypass, gp_fault and ss_fault are 0.
- R2: A request sampled with req_valid high at a clock edge produces rsp_valid high for exactly the following cycle. On a buffer hit, rsp_ppn equals the stored physical page of the matching entry and rsp_miss is 0.
- R3: When no valid entry holds the request's page number, rsp_miss is 1 and rsp_ppn is 0. That request sets neither fault flag, even when it also breaks a limit or writes a protected page.
- R4: For segment codes 0, 1, 3, 4 and 5, a hit whose last byte (effective address plus size in bytes minus one, computed one bit wider than the address so that it cannot wrap) exceeds the segment's limit sets gp_fault. A multi-byte access that straddles the limit also sets it.
- R5: The same limit overrun on segment code 2 sets ss_fault and leaves gp_fault unchanged.
- R6: A write that hits an entry marked read-only sets gp_fault. A read of that entry, or a write to a writable entry, sets nothing.
- R7: When a limit overrun and a read-only write occur together, only the limit fault is reported. On the stack segment this means ss_fault is set and gp_fault is not.
- R8: rsp_bypass is 1 when the request is in I/O space, or when it hits an entry whose cache-disable flag is set. Otherwise it is 0.
- R9: gp_fault and ss_fault stay set until flt_clear is sampled high. A fault raised in the same cycle as the clear is kept.
- R10: A configuration write updates the segment limit or the buffer entry for requests presented from the next cycle onward. When several valid entries hold the same page number, the entry with the lowest index supplies the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| seg_wr | input | 1 | Write strobe for a segment limit |
| seg_idx | input | 3 | Segment code whose limit is written |
| seg_limit | input | ADDR_W | New limit (highest valid offset) |
| tlb_wr | input | 1 | Write strobe for a translation entry |
| tlb_idx | input | log2(TLB_ENTRIES) | Entry index to write |
| tlb_vpn | input | ADDR_W-PAGE_BITS | Virtual page number of the entry |
| tlb_ppn | input | PPN_W | Physical page number of the entry |
| tlb_ro | input | 1 | Entry is read-only |
| tlb_nocache | input | 1 | Entry bypasses the cache |
| tlb_vld | input | 1 | Entry is valid |
| req_valid | input | 1 | Request present this cycle |
| req_seg | input | 3 | Segment code of the request |
| req_ea | input | ADDR_W | Effective address within the segment |
| req_size | input | 2 | Access size code |
| req_write | input | 1 | Request is a write |
| req_vpn | input | ADDR_W-PAGE_BITS | Virtual page number of the request |
| req_io | input | 1 | Request targets I/O space |
| flt_clear | input | 1 | Clears both sticky fault flags |
| rsp_valid | output | 1 | Response fields below are fresh |
| rsp_ppn | output | PPN_W | Translated physical page |
| rsp_miss | output | 1 | No entry matched |
| rsp_bypass | output | 1 | Access must go straight to the bus |
| gp_fault | output | 1 | Sticky general-protection fault |
| ss_fault | output | 1 | Sticky stack-segment fault |

## Verification
The directed cases sit on the edge of each limit. A 4-byte read ending exactly on the limit must pass, and the same read one byte higher must fault. A design that compared only the start address would miss the second fault. An access at the top of the address space with an all-ones limit must also fault; a design that truncated the sum would let it through as a wrapped small address. A stack overrun combined with a read-only write targets both the fault-type split and the priority rule: a wrong design raises gp_fault as well as, or instead of, ss_fault. Missed requests that break limits, duplicate page numbers in the buffer, and a clear arriving in the same cycle as a new fault catch designs that fault on misses, pick the wrong entry, or let the clear win. Seeded random requests near each limit cover the remaining combinations.

// File: rtl/mpc_pkg.sv
package mpc_pkg;

   // width of the segment code carried by requests and limit writes
   localparam int unsigned SEL_W = 3;

   localparam logic [SEL_W-1:0] SEG_ES = 3'd0;
   localparam logic [SEL_W-1:0] SEG_CS = 3'd1;
   localparam logic [SEL_W-1:0] SEG_SS = 3'd2;
   localparam logic [SEL_W-1:0] SEG_DS = 3'd3;
   localparam logic [SEL_W-1:0] SEG_FS = 3'd4;
   localparam logic [SEL_W-1:0] SEG_GS = 3'd5;

   typedef enum logic [1:0] {
      SZ_B1 = 2'd0,
      SZ_B2 = 2'd1,
      SZ_B4 = 2'd2,
      SZ_B8 = 2'd3
   } acc_size_e;

   // offset from first to last byte of an access
   function automatic logic [2:0] span_of(input acc_size_e sz);
      case (sz)
         SZ_B1:   return 3'd0;
         SZ_B2:   return 3'd1;
         SZ_B4:   return 3'd3;
         default: return 3'd7;
      endcase
   endfunction

endpackage

// File: rtl/mpc_seg_limit.sv
module mpc_seg_limit
   import mpc_pkg::*;
#(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned NUM_SEGS = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [ADDR_W-1:0] wr_limit,
   input  logic [SEL_W-1:0]  rd_sel,
   input  logic [ADDR_W-1:0] ea,
   input  logic [1:0]        size,
   output logic              over_limit
);
   localparam int unsigned CMP_W  = ADDR_W + 1;
   localparam int unsigned FLAT_W = NUM_SEGS * ADDR_W;

   if (NUM_SEGS > (1 << SEL_W)) begin : g_bad_segs
      $error("NUM_SEGS does not fit the segment code width");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W too small");
   end

   logic [FLAT_W-1:0] lim_flat;
   logic [ADDR_W-1:0] lim_sel;
   logic [CMP_W-1:0]  last_byte;

   for (genvar s = 0; s < NUM_SEGS; s++) begin : g_seg
      logic [ADDR_W-1:0] lim_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            lim_q <= '0;
         else if (wr_en && (wr_sel == SEL_W'(s)))
            lim_q <= wr_limit;
      end
      assign lim_flat[s*ADDR_W +: ADDR_W] = lim_q;
   end

   // codes without a register read a zero limit
   always_comb begin
      lim_sel = '0;
      for (int i = 0; i < NUM_SEGS; i++) begin
         if (rd_sel == SEL_W'(i))
            lim_sel = lim_flat[i*ADDR_W +: ADDR_W];
      end
   end

   always_comb begin
      last_byte  = {1'b0, ea} + CMP_W'(span_of(acc_size_e'(size)));
      over_limit = last_byte > {1'b0, lim_sel};
   end

endmodule

// File: rtl/mpc_tlb.sv
module mpc_tlb #(
   parameter int unsigned ENTRIES = 8,
   parameter int unsigned VPN_W   = 20,
   parameter int unsigned PPN_W   = 20
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [$clog2(ENTRIES)-1:0] wr_idx,
   input  logic [VPN_W-1:0]           wr_vpn,
   input  logic [PPN_W-1:0]           wr_ppn,
   input  logic                       wr_ro,
   input  logic                       wr_nc,
   input  logic                       wr_vld,
   input  logic [VPN_W-1:0]           lk_vpn,
   output logic                       hit,
   output logic [PPN_W-1:0]           hit_ppn,
   output logic                       hit_ro,
   output logic                       hit_nc
);
   localparam int unsigned IDX_W  = $clog2(ENTRIES);
   localparam int unsigned ENT_W  = PPN_W + 2;
   localparam int unsigned FLAT_W = ENTRIES * ENT_W;

   if (ENTRIES < 2) begin : g_bad_entries
      $error("ENTRIES must be at least 2");
   end
   if (ENTRIES > 64) begin : g_big_entries
      $error("ENTRIES above 64 makes the match tree too deep");
   end

   logic [FLAT_W-1:0]  ent_flat;
   logic [ENTRIES-1:0] match;
   logic [ENT_W-1:0]   pick;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic             vld_q;
      logic             ro_q;
      logic             nc_q;
      logic [VPN_W-1:0] vpn_q;
      logic [PPN_W-1:0] ppn_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q <= 1'b0;
            ro_q  <= 1'b0;
            nc_q  <= 1'b0;
            vpn_q <= '0;
            ppn_q <= '0;
         end else if (wr_en && (wr_idx == IDX_W'(e))) begin
            vld_q <= wr_vld;
            ro_q  <= wr_ro;
            nc_q  <= wr_nc;
            vpn_q <= wr_vpn;
            ppn_q <= wr_ppn;
         end
      end

      assign match[e] = vld_q && (vpn_q == lk_vpn);
      assign ent_flat[e*ENT_W +: ENT_W] = {ro_q, nc_q, ppn_q};
   end

   // lowest matching index wins: scan downward so it is assigned last
   always_comb begin
      pick = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (match[i])
            pick = ent_flat[i*ENT_W +: ENT_W];
      end
   end

   assign hit     = |match;
   assign hit_ro  = pick[ENT_W-1];
   assign hit_nc  = pick[ENT_W-2];
   assign hit_ppn = pick[PPN_W-1:0];

endmodule

// File: rtl/mpc_fault_resolve.sv
module mpc_fault_resolve #(
   parameter int unsigned PPN_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic             req_io,
   input  logic             is_stack,
   input  logic             over_limit,
   input  logic             hit,
   input  logic [PPN_W-1:0] hit_ppn,
   input  logic             hit_ro,
   input  logic             hit_nc,
   input  logic             flt_clear,
   output logic             rsp_valid,
   output logic [PPN_W-1:0] rsp_ppn,
   output logic             rsp_miss,
   output logic             rsp_bypass,
   output logic             gp_fault,
   output logic             ss_fault
);
   logic lim_flt;
   logic wp_flt;
   logic set_gp;
   logic set_ss;

   always_comb begin
      // a miss hides every fault; a limit fault hides write protection
      lim_flt = hit && over_limit;
      wp_flt  = hit && req_write && hit_ro && !over_limit;
      set_ss  = req_valid && lim_flt && is_stack;
      set_gp  = req_valid && ((lim_flt && !is_stack) || wp_flt);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_ppn    <= '0;
         rsp_miss   <= 1'b0;
         rsp_bypass <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_ppn    <= hit_ppn;
            rsp_miss   <= !hit;
            rsp_bypass <= req_io || (hit && hit_nc);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gp_fault <= 1'b0;
         ss_fault <= 1'b0;
      end else begin
         gp_fault <= set_gp || (gp_fault && !flt_clear);
         ss_fault <= set_ss || (ss_fault && !flt_clear);
      end
   end

endmodule

// File: rtl/mem_prot_check.sv
module mem_prot_check
   import mpc_pkg::*;
#(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned PAGE_BITS   = 12,
   parameter int unsigned PPN_W       = 20,
   parameter int unsigned TLB_ENTRIES = 8,
   parameter int unsigned NUM_SEGS    = 6
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           seg_wr,
   input  logic [SEL_W-1:0]               seg_idx,
   input  logic [ADDR_W-1:0]              seg_limit,
   input  logic                           tlb_wr,
   input  logic [$clog2(TLB_ENTRIES)-1:0] tlb_idx,
   input  logic [ADDR_W-PAGE_BITS-1:0]    tlb_vpn,
   input  logic [PPN_W-1:0]               tlb_ppn,
   input  logic                           tlb_ro,
   input  logic                           tlb_nocache,
   input  logic                           tlb_vld,
   input  logic                           req_valid,
   input  logic [SEL_W-1:0]               req_seg,
   input  logic [ADDR_W-1:0]              req_ea,
   input  logic [1:0]                     req_size,
   input  logic                           req_write,
   input  logic [ADDR_W-PAGE_BITS-1:0]    req_vpn,
   input  logic                           req_io,
   input  logic                           flt_clear,
   output logic                           rsp_valid,
   output logic [PPN_W-1:0]               rsp_ppn,
   output logic                           rsp_miss,
   output logic                           rsp_bypass,
   output logic                           gp_fault,
   output logic                           ss_fault
);
   localparam int unsigned VPN_W = ADDR_W - PAGE_BITS;

   if (PAGE_BITS < 1 || PAGE_BITS >= ADDR_W) begin : g_bad_page
      $error("PAGE_BITS must leave a non-empty page number");
   end
   if (NUM_SEGS <= int'(SEG_SS)) begin : g_no_stack
      $error("NUM_SEGS must include the stack segment code");
   end

   logic             over_limit;
   logic             hit;
   logic [PPN_W-1:0] hit_ppn;
   logic             hit_ro;
   logic             hit_nc;
   logic             is_stack;

   assign is_stack = (req_seg == SEG_SS);

   mpc_seg_limit #(
      .ADDR_W   (ADDR_W),
      .NUM_SEGS (NUM_SEGS)
   ) i_seg_limit (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (seg_wr),
      .wr_sel     (seg_idx),
      .wr_limit   (seg_limit),
      .rd_sel     (req_seg),
      .ea         (req_ea),
      .size       (req_size),
      .over_limit (over_limit)
   );

   mpc_tlb #(
      .ENTRIES (TLB_ENTRIES),
      .VPN_W   (VPN_W),
      .PPN_W   (PPN_W)
   ) i_tlb (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (tlb_wr),
      .wr_idx  (tlb_idx),
      .wr_vpn  (tlb_vpn),
      .wr_ppn  (tlb_ppn),
      .wr_ro   (tlb_ro),
      .wr_nc   (tlb_nocache),
      .wr_vld  (tlb_vld),
      .lk_vpn  (req_vpn),
      .hit     (hit),
      .hit_ppn (hit_ppn),
      .hit_ro  (hit_ro),
      .hit_nc  (hit_nc)
   );

   mpc_fault_resolve #(
      .PPN_W (PPN_W)
   ) i_resolve (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_write  (req_write),
      .req_io     (req_io),
      .is_stack   (is_stack),
      .over_limit (over_limit),
      .hit        (hit),
      .hit_ppn    (hit_ppn),
      .hit_ro     (hit_ro),
      .hit_nc     (hit_nc),
      .flt_clear  (flt_clear),
      .rsp_valid  (rsp_valid),
      .rsp_ppn    (rsp_ppn),
      .rsp_miss   (rsp_miss),
      .rsp_bypass (rsp_bypass),
      .gp_fault   (gp_fault),
      .ss_fault   (ss_fault)
   );

endmodule

// File: rtl/mem_prot_check_sva.sv
module mem_prot_check_sva #(
   parameter int unsigned PPN_W = 20
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_io,
   input logic             flt_clear,
   input logic             rsp_valid,
   input logic [PPN_W-1:0] rsp_ppn,
   input logic             rsp_miss,
   input logic             rsp_bypass,
   input logic             gp_fault,
   input logic             ss_fault
);

   assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   assert_no_rsp_without_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   assert_miss_zero_page_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_miss) |-> (rsp_ppn == '0));

   assert_miss_no_gp_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gp_fault) |-> (rsp_valid && !rsp_miss));

   assert_miss_no_ss_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ss_fault) |-> (rsp_valid && !rsp_miss));

   assert_one_fault_kind_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !($rose(gp_fault) && $rose(ss_fault)));

   assert_io_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_io) |=> rsp_bypass);

   assert_gp_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (gp_fault && !flt_clear) |=> gp_fault);

   assert_ss_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ss_fault && !flt_clear) |=> ss_fault);

endmodule

bind mem_prot_check mem_prot_check_sva #(.PPN_W(PPN_W)) i_sva (.*);

// File: tb/test_mem_prot_check.sv
`timescale 1ns/1ps
module test_mem_prot_check;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        seg_wr = 1'b0;
   logic [2:0]  seg_idx = '0;
   logic [31:0] seg_limit = '0;
   logic        tlb_wr = 1'b0;
   logic [2:0]  tlb_idx = '0;
   logic [19:0] tlb_vpn = '0;
   logic [19:0] tlb_ppn = '0;
   logic        tlb_ro = 1'b0;
   logic        tlb_nocache = 1'b0;
   logic        tlb_vld = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_seg = '0;
   logic [31:0] req_ea = '0;
   logic [1:0]  req_size = '0;
   logic        req_write = 1'b0;
   logic [19:0] req_vpn = '0;
   logic        req_io = 1'b0;
   logic        flt_clear = 1'b0;
   logic        rsp_valid;
   logic [19:0] rsp_ppn;
   logic        rsp_miss;
   logic        rsp_bypass;
   logic        gp_fault;
   logic        ss_fault;

   int unsigned n_chk = 0;
   int unsigned n_bad = 0;

   // reference state
   logic [31:0] lim_m [8];
   logic        v_m  [8];
   logic        ro_m [8];
   logic        nc_m [8];
   logic [19:0] vpn_m[8];
   logic [19:0] ppn_m[8];
   logic        gp_m = 1'b0;
   logic        ss_m = 1'b0;

   always #4 clk = ~clk;

   mem_prot_check i_mem_prot_check (.*);

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic void model(input logic [2:0] seg, input logic [31:0] ea, input logic [1:0] sz,
                                 input logic wr, input logic [19:0] vpn, input logic io,
                                 output logic hit, output logic [19:0] ppn, output logic byp,
                                 output logic sgp, output logic sss);
      logic [32:0] last;
      logic        over;
      int          k;
      hit = 1'b0; ppn = '0; k = -1;
      for (int i = 0; i < 8; i++)
         if (k < 0 && v_m[i] && vpn_m[i] == vpn) k = i;
      if (k >= 0) begin hit = 1'b1; ppn = ppn_m[k]; end
      last = {1'b0, ea} + 33'((1 << sz) - 1);
      over = last > {1'b0, lim_m[seg]};
      byp  = io || (hit && nc_m[k < 0 ? 0 : k]);
      sgp  = 1'b0; sss = 1'b0;
      if (hit) begin
         if (over) begin
            if (seg == 3'd2) sss = 1'b1; else sgp = 1'b1;
         end else if (wr && ro_m[k]) sgp = 1'b1;
      end
   endfunction

   task automatic set_lim(input logic [2:0] idx, input logic [31:0] val);
      @(negedge clk);
      seg_wr = 1'b1; seg_idx = idx; seg_limit = val;
      @(negedge clk);
      seg_wr = 1'b0;
      lim_m[idx] = val;
   endtask

   task automatic set_tlb(input logic [2:0] idx, input logic vld, input logic [19:0] vpn,
                          input logic [19:0] ppn, input logic ro, input logic nc);
      @(negedge clk);
      tlb_wr = 1'b1; tlb_idx = idx; tlb_vld = vld; tlb_vpn = vpn;
      tlb_ppn = ppn; tlb_ro = ro; tlb_nocache = nc;
      @(negedge clk);
      tlb_wr = 1'b0;
      v_m[idx] = vld; vpn_m[idx] = vpn; ppn_m[idx] = ppn; ro_m[idx] = ro; nc_m[idx] = nc;
   endtask

   task automatic issue(input string tag, input logic [2:0] seg, input logic [31:0] ea,
                        input logic [1:0] sz, input logic wr, input logic [19:0] vpn,
                        input logic io, input logic clr);
      logic        hit, byp, sgp, sss;
      logic [19:0] ppn;
      model(seg, ea, sz, wr, vpn, io, hit, ppn, byp, sgp, sss);
      @(negedge clk);
      req_valid = 1'b1; req_seg = seg; req_ea = ea; req_size = sz;
      req_write = wr; req_vpn = vpn; req_io = io; flt_clear = clr;
      @(negedge clk);
      req_valid = 1'b0; flt_clear = 1'b0;
      gp_m = sgp || (gp_m && !clr);
      ss_m = sss || (ss_m && !clr);
      chk(tag, "rsp_valid",  32'(rsp_valid),  32'd1);
      chk(tag, "rsp_ppn",    32'(rsp_ppn),    32'(ppn));
      chk(tag, "rsp_miss",   32'(rsp_miss),   32'(!hit));
      chk(tag, "rsp_bypass", 32'(rsp_bypass), 32'(byp));
      chk(tag, "gp_fault",   32'(gp_fault),   32'(gp_m));
      chk(tag, "ss_fault",   32'(ss_fault),   32'(ss_m));
   endtask

   task automatic clear_flags(input string tag);
      @(negedge clk);
      flt_clear = 1'b1;
      @(negedge clk);
      flt_clear = 1'b0;
      gp_m = 1'b0; ss_m = 1'b0;
      chk(tag, "gp_fault after clear", 32'(gp_fault), 32'd0);
      chk(tag, "ss_fault after clear", 32'(ss_fault), 32'd0);
      chk(tag, "rsp_valid idle", 32'(rsp_valid), 32'd0);
   endtask

   initial begin
      for (int i = 0; i < 8; i++) begin
         lim_m[i] = '0; v_m[i] = 1'b0; ro_m[i] = 1'b0; nc_m[i] = 1'b0;
         vpn_m[i] = '0; ppn_m[i] = '0;
      end
      void'($urandom(32'h5EED_0042));

      // R1: reset state, during reset and first cycle after
      repeat (3) @(negedge clk);
      chk("R1", "rsp_valid in reset", 32'(rsp_valid), 32'd0);
      chk("R1", "gp_fault in reset",  32'(gp_fault),  32'd0);
      chk("R1", "ss_fault in reset",  32'(ss_fault),  32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "rsp_miss after reset",   32'(rsp_miss),   32'd0);
      chk("R1", "rsp_bypass after reset", 32'(rsp_bypass), 32'd0);

      // configuration (R10)
      set_lim(3'd0, 32'h0000_0FFF);
      set_lim(3'd1, 32'h0000_FFFF);
      set_lim(3'd2, 32'h0000_07FF);
      set_lim(3'd3, 32'h0000_1FFF);
      set_lim(3'd4, 32'h0000_3FFF);
      set_lim(3'd5, 32'hFFFF_FFFF);
      set_tlb(3'd0, 1'b1, 20'h00010, 20'h00200, 1'b0, 1'b0);
      set_tlb(3'd1, 1'b1, 20'h00011, 20'h00301, 1'b1, 1'b0);
      set_tlb(3'd2, 1'b1, 20'h00012, 20'h00402, 1'b0, 1'b1);
      set_tlb(3'd3, 1'b1, 20'h00013, 20'h00503, 1'b1, 1'b1);
      set_tlb(3'd5, 1'b1, 20'h00010, 20'h00999, 1'b0, 1'b0);

      // R2 + R10: hit, duplicate page resolved to lowest index
      issue("R2 R10 hit lowest index", 3'd3, 32'h100, 2'd2, 1'b0, 20'h00010, 1'b0, 1'b0);
      // R4: last byte exactly on the limit passes, one more straddles and faults
      issue("R4 on limit", 3'd3, 32'h1FFC, 2'd2, 1'b0, 20'h00010, 1'b0, 1'b0);
      issue("R4 straddle", 3'd3, 32'h1FFD, 2'd2, 1'b0, 20'h00010, 1'b0, 1'b0);
      clear_flags("R9 clear after R4");
      // R4: no wrap at the top of the address space
      issue("R4 wrap", 3'd5, 32'hFFFF_FFFF, 2'd1, 1'b0, 20'h00010, 1'b0, 1'b0);
      clear_flags("R9 clear after wrap");
      // R5: stack overrun sets ss only
      issue("R5 stack overrun", 3'd2, 32'h800, 2'd0, 1'b0, 20'h00010, 1'b0, 1'b0);
      // R9: held across idle cycles
      repeat (4) @(negedge clk);
      chk("R9", "ss_fault held", 32'(ss_fault), 32'd1);
      clear_flags("R9 clear after R5");
      // R6: read-only page
      issue("R6 read of ro", 3'd3, 32'h10, 2'd2, 1'b0, 20'h00011, 1'b0, 1'b0);
      issue("R6 write to rw", 3'd3, 32'h10, 2'd2, 1'b1, 20'h00010, 1'b0, 1'b0);
      issue("R6 write to ro", 3'd3, 32'h10, 2'd2, 1'b1, 20'h00011, 1'b0, 1'b0);
      clear_flags("R9 clear after R6");
      // R7: priority of limit over write protection on the stack
      issue("R7 stack priority", 3'd2, 32'h7FF, 2'd1, 1'b1, 20'h00011, 1'b0, 1'b0);
      clear_flags("R9 clear after R7");
      // R3: miss hides a limit overrun and a write
      issue("R3 miss", 3'd3, 32'hFFFF, 2'd3, 1'b1, 20'h00077, 1'b0, 1'b0);
      // R8: bypass sources
      issue("R8 nocache page", 3'd1, 32'h20, 2'd0, 1'b0, 20'h00012, 1'b0, 1'b0);
      issue("R8 io space", 3'd1, 32'h20, 2'd0, 1'b0, 20'h00010, 1'b1, 1'b0);
      issue("R8 io on miss", 3'd1, 32'h20, 2'd0, 1'b0, 20'h00077, 1'b1, 1'b0);
      // R9: clear in the same cycle as a new fault keeps the fault
      issue("R9 set-over-clear", 3'd0, 32'h1000, 2'd0, 1'b0, 20'h00013, 1'b0, 1'b1);
      clear_flags("R9 clear final");
      // R10: invalidate entry 0, the duplicate in entry 5 now answers; change a limit
      set_tlb(3'd0, 1'b0, 20'h00010, 20'h00200, 1'b0, 1'b0);
      issue("R10 invalidated entry", 3'd3, 32'h0, 2'd0, 1'b0, 20'h00010, 1'b0, 1'b0);
      set_lim(3'd3, 32'h0000_00FF);
      issue("R10 new limit", 3'd3, 32'h100, 2'd0, 1'b0, 20'h00010, 1'b0, 1'b0);

      // seeded random mix around every limit
      for (int n = 0; n < 400; n++) begin
         logic [2:0]  s;
         logic [31:0] ea;
         s = 3'($urandom % 6);
         if ($urandom % 2 == 0)
            ea = lim_m[s] + 32'($urandom % 16) - 32'd8;
         else
            ea = $urandom;
         issue("random R2 R3 R4 R5 R6 R7 R8 R9", s, ea, 2'($urandom % 4), 1'($urandom % 2),
               20'h00010 + 20'($urandom % 5), ($urandom % 8) == 0, ($urandom % 5) == 0);
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule